// File: doc/BRIEF.md
# Associative Road Matching Memory

This block is the pattern-matching stage of a silicon track trigger. It holds a table of roads. Each road is one candidate track above the trigger's transverse-momentum threshold. A road is stored as five hit parameters: one from the coarse tracker on layer 0, and one cluster position for each silicon layer 1 to 4. During a bunch crossing, hit words stream in. Each carries a layer number and a value. All roads compare the hit against their stored value for that layer in parallel, like a content-addressable memory. Each road that agrees marks that layer as seen.

When the end-of-event strobe arrives, the lookup runs in reverse. Every road with all of its required layers marked is reported by index on an output stream. A single beat flagged as "none" is sent if no road qualifies. Per-road layer marks are cleared as the final beat is taken, so the next event starts from nothing.

Roads are loaded through a configuration port while the block is collecting hits. Each road has an enable bit, so unused entries never match. Each road also has a per-layer "required" mask, so a road can ignore a layer. Both the configuration port and the hit port are valid/ready. Their ready signals are low for the whole readout, which applies back-pressure to upstream until the result stream has drained. The result stream is valid/ready as well. A beat is held unchanged until the consumer raises ready.

Top module: `roadfind_top`

## Requirements
- R1: After reset, out_valid is low, hit_ready and cfg_ready are high, and every road is disabled, so an immediate end of event yields only the "none" beat.
- R2: A configuration beat accepted while cfg_ready is high replaces the addressed road. Its stored value for layer L is cfg_pattern[L*HIT_W +: HIT_W], with layer 0 the coarse tracker and layers 1 to 4 silicon. Bit L of cfg_need marks layer L as required, and cfg_enable enables the road. The write also clears that road's layer marks.
- R3: An accepted hit word with layer L (0 to 4) and value V marks layer L in every enabled road whose stored value for layer L equals V. Hit words with a layer number of 5, 6 or 7 mark nothing.
- R4: At end of event, a road matches when it is enabled and every required layer is marked. Unrequired layers do not matter. A disabled road never matches.
- R5: An eoe pulse while collecting starts readout on the next clock. A hit word accepted in the same cycle as eoe counts toward that event.
- R6: Matching road indices are emitted in ascending order, one per accepted beat. out_last is high only on the final beat.
- R7: When no road matches, exactly one beat is emitted with out_none high, out_last high and out_index zero.
- R8: While out_valid is high and out_ready is low, out_index, out_none and out_last hold their values.
- R9: During readout, hit_ready and cfg_ready are low. Hit words, configuration beats and eoe pulses offered then have no effect.
- R10: After the final beat is accepted, the block returns to collecting on the next cycle, with all layer marks cleared.
- R11: Marks accumulate over any number of hit words within one event. A repeated or non-matching hit word on an already marked layer leaves it marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration beat offered |
| cfg_ready | output | 1 | Configuration beat can be taken (collecting) |
| cfg_addr | input | IDX_W | Road index to write |
| cfg_pattern | input | 5*HIT_W | Stored hit value per layer, layer L at bits L*HIT_W |
| cfg_need | input | 5 | Required-layer mask, bit L for layer L |
| cfg_enable | input | 1 | Road enable |
| hit_valid | input | 1 | Hit word offered |
| hit_ready | output | 1 | Hit word can be taken (collecting) |
| hit_layer | input | 3 | Layer number of the hit |
| hit_value | input | HIT_W | Hit parameter |
| eoe | input | 1 | End-of-event strobe |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_index | output | IDX_W | Matching road index |
| out_none | output | 1 | No road matched this event |
| out_last | output | 1 | Final beat of the event |

## Verification
On every cycle, the assertions check the stream rules of the result port. They check that a stalled beat holds steady, that indices climb between consecutive beats, and that the "none" beat is also the last beat at index zero. They also check that the input ports are blocked for the whole readout and that readout starts one cycle after an accepted eoe. Only the bench scenarios can show which roads match. This covers the per-layer comparison, the required-layer mask, disabled roads, ignored layer numbers and a hit that coincides with eoe. It also covers marks being cleared between events, input offered during readout being lost rather than deferred, and the full 128-entry sweep up to the top index.

// File: rtl/roadfind_pkg.sv
package roadfind_pkg;
  localparam int LAYERS = 5;
  localparam int LID_W  = 3;
  typedef enum logic {ST_COLLECT, ST_READOUT} rd_state_e;
endpackage

// File: rtl/roadfind_cell.sv
// One road: stored pattern, required-layer mask, enable and layer marks.
module roadfind_cell #(
  parameter int HIT_W  = 8,
  parameter int LAYERS = 5,
  parameter int LID_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [LAYERS*HIT_W-1:0]   load_pat,
  input  logic [LAYERS-1:0]         load_need,
  input  logic                      load_en,
  input  logic                      hit_fire,
  input  logic [LID_W-1:0]          hit_layer,
  input  logic [HIT_W-1:0]          hit_value,
  input  logic                      clear,
  output logic                      full
);
  logic [LAYERS*HIT_W-1:0] pat;
  logic [LAYERS-1:0]       need;
  logic                    en;
  logic [LAYERS-1:0]       seen;
  logic [LAYERS-1:0]       hit_mark;
  logic [LAYERS-1:0]       seen_nxt;

  always_comb begin
    hit_mark = '0;
    for (int l = 0; l < LAYERS; l++) begin
      if (hit_fire && en && (hit_layer == LID_W'(l)) &&
          (pat[l*HIT_W +: HIT_W] == hit_value))
        hit_mark[l] = 1'b1;
    end
  end

  assign seen_nxt = seen | hit_mark;
  // Full match as it will stand after this cycle's hit, so a hit that
  // coincides with end of event is counted.
  assign full = en && (&(seen_nxt | ~need));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      need <= '0;
      seen <= '0;
    end else if (load) begin
      en   <= load_en;
      need <= load_need;
      seen <= '0;
    end else if (clear) begin
      seen <= '0;
    end else begin
      seen <= seen_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (load) pat <= load_pat;
  end
endmodule

// File: rtl/roadfind_lowest.sv
// Finds the lowest set bit of a vector.
module roadfind_lowest #(
  parameter int W  = 128,
  parameter int IW = 7
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/roadfind_readout.sv
// Captures the match vector at end of event and drains it in index order.
module roadfind_readout
  import roadfind_pkg::*;
#(
  parameter int N  = 128,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eoe,
  input  logic [N-1:0]  full_vec,
  input  logic          out_ready,
  output logic          collecting,
  output logic          out_valid,
  output logic [IW-1:0] out_index,
  output logic          out_none,
  output logic          out_last,
  output logic          clear_marks
);
  rd_state_e    state;
  logic [N-1:0] pend;
  logic [N-1:0] rest;
  logic [IW-1:0] low_idx;
  logic          low_any;

  roadfind_lowest #(.W(N), .IW(IW)) u_low (
    .vec (pend),
    .idx (low_idx),
    .any (low_any)
  );

  assign rest        = pend & (pend - N'(1));
  assign collecting  = (state == ST_COLLECT);
  assign out_valid   = (state == ST_READOUT);
  assign out_none    = out_valid && !low_any;
  assign out_last    = out_valid && (rest == '0);
  assign out_index   = low_any ? low_idx : '0;
  assign clear_marks = out_valid && out_ready && out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_COLLECT;
      pend  <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (eoe) begin
            pend  <= full_vec;
            state <= ST_READOUT;
          end
        end
        ST_READOUT: begin
          if (out_ready) begin
            if (out_last) begin
              pend  <= '0;
              state <= ST_COLLECT;
            end else begin
              pend <= rest;
            end
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/roadfind_top.sv
module roadfind_top
  import roadfind_pkg::*;
#(
  parameter int N_ROADS = 128,
  parameter int HIT_W   = 8,
  localparam int IDX_W  = $clog2(N_ROADS),
  localparam int PAT_W  = LAYERS * HIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [PAT_W-1:0]  cfg_pattern,
  input  logic [LAYERS-1:0] cfg_need,
  input  logic              cfg_enable,
  input  logic              hit_valid,
  output logic              hit_ready,
  input  logic [LID_W-1:0]  hit_layer,
  input  logic [HIT_W-1:0]  hit_value,
  input  logic              eoe,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_index,
  output logic              out_none,
  output logic              out_last
);
  logic               collecting;
  logic               cfg_fire;
  logic               hit_fire;
  logic               clear_marks;
  logic [N_ROADS-1:0] full_vec;

  assign cfg_ready = collecting;
  assign hit_ready = collecting;
  assign cfg_fire  = cfg_valid && collecting;
  assign hit_fire  = hit_valid && collecting;

  for (genvar g = 0; g < N_ROADS; g++) begin : g_road
    roadfind_cell #(.HIT_W(HIT_W), .LAYERS(LAYERS), .LID_W(LID_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_fire && (cfg_addr == IDX_W'(g))),
      .load_pat  (cfg_pattern),
      .load_need (cfg_need),
      .load_en   (cfg_enable),
      .hit_fire  (hit_fire),
      .hit_layer (hit_layer),
      .hit_value (hit_value),
      .clear     (clear_marks),
      .full      (full_vec[g])
    );
  end

  roadfind_readout #(.N(N_ROADS), .IW(IDX_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .eoe         (eoe),
    .full_vec    (full_vec),
    .out_ready   (out_ready),
    .collecting  (collecting),
    .out_valid   (out_valid),
    .out_index   (out_index),
    .out_none    (out_none),
    .out_last    (out_last),
    .clear_marks (clear_marks)
  );
endmodule

// File: rtl/roadfind_chk.sv
module roadfind_chk #(
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hit_ready,
  input logic          cfg_ready,
  input logic          eoe,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_index,
  input logic          out_none,
  input logic          out_last
);
  a_r9_inputs_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!hit_ready && !cfg_ready));

  a_r7_none_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_none |-> (out_last && out_index == '0));

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index) &&
                                   $stable(out_none) && $stable(out_last)));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_index > $past(out_index)));

  a_r10_back_to_collect: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && hit_ready && cfg_ready));

  a_r5_readout_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (eoe && hit_ready) |=> out_valid);
endmodule

bind roadfind_top roadfind_chk #(.IW(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hit_ready (hit_ready),
  .cfg_ready (cfg_ready),
  .eoe       (eoe),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_index (out_index),
  .out_none  (out_none),
  .out_last  (out_last)
);

// File: tb/sim_roadfind_top.sv
module sim_roadfind_top;
  localparam int CLK_P = 10;
  localparam int N     = 128;
  localparam int HW    = 8;
  localparam int IW    = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [IW-1:0] cfg_addr = '0;
  logic [5*HW-1:0] cfg_pattern = '0;
  logic [4:0]    cfg_need = '0;
  logic          cfg_enable = 1'b0;
  logic          hit_valid = 1'b0;
  logic          hit_ready;
  logic [2:0]    hit_layer = '0;
  logic [HW-1:0] hit_value = '0;
  logic          eoe = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [IW-1:0] out_index;
  logic          out_none;
  logic          out_last;

  int checks = 0;
  int errors = 0;

  logic [5*HW-1:0] m_pat  [N];
  logic [4:0]      m_need [N];
  logic            m_en   [N];
  logic [4:0]      m_seen [N];

  always #(CLK_P/2) clk = ~clk;

  roadfind_top #(.N_ROADS(N), .HIT_W(HW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_road(input int r, input logic [5*HW-1:0] p,
                            input logic [4:0] nd, input bit en);
    cfg_valid = 1'b1; cfg_addr = IW'(r); cfg_pattern = p;
    cfg_need = nd; cfg_enable = en;
    m_pat[r] = p; m_need[r] = nd; m_en[r] = en; m_seen[r] = '0;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic model_hit(input int l, input logic [HW-1:0] v);
    if (l < 5)
      for (int r = 0; r < N; r++)
        if (m_en[r] && m_pat[r][l*HW +: HW] == v) m_seen[r][l] = 1'b1;
  endtask

  task automatic send_hit(input int l, input logic [HW-1:0] v, input bit with_eoe);
    hit_valid = 1'b1; hit_layer = 3'(l); hit_value = v; eoe = with_eoe;
    model_hit(l, v);
    @(negedge clk);
    hit_valid = 1'b0; eoe = 1'b0;
  endtask

  task automatic send_road_hits(input logic [5*HW-1:0] p);
    for (int l = 0; l < 5; l++) send_hit(l, p[l*HW +: HW], 1'b0);
  endtask

  task automatic pulse_eoe();
    eoe = 1'b1;
    @(negedge clk);
    eoe = 1'b0;
  endtask

  // Drains one readout, comparing against the bench model.
  task automatic drain(input string req, input bit stall);
    int exp_q[$];
    int b = 0;
    int cyc = 0;
    bit done = 0;
    for (int r = 0; r < N; r++)
      if (m_en[r] && (&(m_seen[r] | ~m_need[r]))) exp_q.push_back(r);
    while (!done && cyc < 600) begin
      out_ready = stall ? (cyc % 3 == 2) : 1'b1;
      #1;
      chk(out_valid === 1'b1, req, int'(out_valid), 1);
      if (exp_q.size() == 0) begin
        chk(out_none === 1'b1 && out_last === 1'b1 && out_index == '0,
            {req, " none beat"}, int'(out_none), 1);
        if (out_ready) done = 1;
      end else begin
        chk(int'(out_index) == exp_q[b], req, int'(out_index), exp_q[b]);
        chk(out_last === (b == exp_q.size() - 1), {req, " last"}, int'(out_last),
            int'(b == exp_q.size() - 1));
        chk(out_none === 1'b0, {req, " none"}, int'(out_none), 0);
        if (out_ready) begin
          b++;
          if (b == exp_q.size()) done = 1;
        end
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    #1;
    chk(out_valid === 1'b0 && hit_ready === 1'b1, "R10 back to collect",
        int'(out_valid), 0);
    for (int r = 0; r < N; r++) m_seen[r] = '0;
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(hit_ready === 1'b1 && cfg_ready === 1'b1, "R1 ready", int'(hit_ready), 1);
    pulse_eoe();
    drain("R1 R7 empty table", 1'b0);
  endtask

  task automatic t_single();
    write_road(10, 40'h11_22_33_44_55, 5'h1F, 1'b1);
    send_hit(2, 8'h99, 1'b0);
    send_road_hits(40'h11_22_33_44_55);
    pulse_eoe();
    drain("R2 R3 R4 single road", 1'b0);
  endtask

  task automatic t_no_match();
    send_hit(0, 8'h55, 1'b0);
    send_hit(1, 8'h44, 1'b0);
    send_hit(2, 8'h33, 1'b0);
    send_hit(3, 8'h22, 1'b0);
    pulse_eoe();
    drain("R7 four of five layers", 1'b0);
  endtask

  task automatic t_multi_stall();
    write_road(2, 40'hA1_A2_A3_A4_A5, 5'h1F, 1'b1);
    write_road(40, 40'hA1_A2_A3_A4_A5, 5'h1F, 1'b1);
    write_road(90, 40'hA1_A2_A3_A4_A5, 5'h1F, 1'b1);
    write_road(41, 40'hA1_A2_A3_A4_B5, 5'h1F, 1'b1);
    send_road_hits(40'hA1_A2_A3_A4_A5);
    pulse_eoe();
    drain("R6 R8 ordered stalled readout", 1'b1);
  endtask

  task automatic t_mask_disable();
    write_road(60, 40'hC1_C2_C3_C4_C5, 5'b00011, 1'b1);
    write_road(61, 40'hC1_C2_C3_C4_C5, 5'b00011, 1'b0);
    send_hit(0, 8'hC5, 1'b0);
    send_hit(1, 8'hC4, 1'b0);
    pulse_eoe();
    drain("R4 mask and disable", 1'b0);
  endtask

  task automatic t_bad_layer();
    write_road(70, 40'h66_66_66_66_66, 5'b00001, 1'b1);
    send_hit(5, 8'h66, 1'b0);
    send_hit(6, 8'h66, 1'b0);
    send_hit(7, 8'h66, 1'b0);
    pulse_eoe();
    drain("R3 layer ids 5-7 ignored", 1'b0);
    send_hit(0, 8'h66, 1'b0);
    pulse_eoe();
    drain("R3 layer 0 marks", 1'b0);
  endtask

  task automatic t_accumulate_clear();
    write_road(80, 40'hD1_D2_D3_D4_D5, 5'h1F, 1'b1);
    send_hit(0, 8'hD5, 1'b0);
    send_hit(0, 8'hD5, 1'b0);
    send_hit(0, 8'h01, 1'b0);
    send_hit(1, 8'hD4, 1'b0);
    send_hit(2, 8'hD3, 1'b0);
    pulse_eoe();
    drain("R11 partial event", 1'b0);
    send_hit(3, 8'hD2, 1'b0);
    send_hit(4, 8'hD1, 1'b0);
    pulse_eoe();
    drain("R10 marks cleared between events", 1'b0);
    send_hit(4, 8'hD1, 1'b0);
    send_hit(2, 8'hD3, 1'b0);
    send_hit(0, 8'hD5, 1'b0);
    send_hit(3, 8'hD2, 1'b0);
    send_hit(1, 8'hD4, 1'b0);
    send_hit(1, 8'h07, 1'b0);
    pulse_eoe();
    drain("R11 accumulated out of order", 1'b0);
  endtask

  task automatic t_same_cycle();
    write_road(100, 40'hE1_E2_E3_E4_E5, 5'h1F, 1'b1);
    send_hit(0, 8'hE5, 1'b0);
    send_hit(1, 8'hE4, 1'b0);
    send_hit(2, 8'hE3, 1'b0);
    send_hit(3, 8'hE2, 1'b0);
    send_hit(4, 8'hE1, 1'b1);
    drain("R5 hit with eoe counts", 1'b0);
  endtask

  task automatic t_blocking();
    write_road(3, 40'hF1_F2_F3_F4_F5, 5'h1F, 1'b1);
    write_road(5, 40'h71_72_73_74_75, 5'h1F, 1'b1);
    send_road_hits(40'hF1_F2_F3_F4_F5);
    pulse_eoe();
    out_ready = 1'b0;
    hit_valid = 1'b1; hit_layer = 3'd0; hit_value = 8'h75;
    cfg_valid = 1'b1; cfg_addr = 7'd3; cfg_pattern = '0; cfg_need = 5'h1F;
    cfg_enable = 1'b0; eoe = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(hit_ready === 1'b0 && cfg_ready === 1'b0, "R9 inputs blocked",
          int'(hit_ready), 0);
      @(negedge clk);
    end
    hit_valid = 1'b0; cfg_valid = 1'b0; eoe = 1'b0;
    drain("R9 readout unaffected", 1'b0);
    send_road_hits(40'hF1_F2_F3_F4_F5);
    send_hit(1, 8'h74, 1'b0);
    send_hit(2, 8'h73, 1'b0);
    send_hit(3, 8'h72, 1'b0);
    send_hit(4, 8'h71, 1'b0);
    pulse_eoe();
    drain("R9 blocked cfg and hit had no effect", 1'b0);
  endtask

  task automatic t_all_roads();
    for (int r = 0; r < N; r++) write_road(r, 40'h0F_1E_2D_3C_4B, 5'h1F, 1'b1);
    send_road_hits(40'h0F_1E_2D_3C_4B);
    pulse_eoe();
    drain("R6 all roads to index 127", 1'b1);
  endtask

  initial begin
    for (int r = 0; r < N; r++) begin
      m_pat[r] = '0; m_need[r] = '0; m_en[r] = 1'b0; m_seen[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_no_match();
    t_multi_stall();
    t_mask_disable();
    t_bad_layer();
    t_accumulate_clear();
    t_same_cycle();
    t_blocking();
    t_all_roads();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule